// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block walks a multi-register memory transfer one 32-bit word at a time. A single start strobe provides a base address, a 16-bit mask that selects registers, a direction (load or store), one of four address-stepping modes and a request to write back the base. The block then emits one item per accepted beat. Each item carries a register index and a word address. After the last item it reports the updated base and, if an overflow check applies, a stack-limit overflow flag.

The item stream uses valid/ready. `xfer_valid_o` stays high while items remain. An item is consumed on a clock edge where valid and ready are both high. While ready is low, the index, address and direction are held unchanged, and the sequence stalls without losing or repeating an item. The other pins are plain control and status signals: the start strobe, the operation fields, busy, the done pulse, writeback, error and overflow. Only whole words move. The number of cycles depends on how many mask bits are set.

Top module: `blk_xfer_seq`

## Requirements
- R1: The number of items consumed equals the number of set mask bits N. Exactly one item is consumed per edge where valid and ready are both high. While ready is low, the index and address of the offered item hold steady.
- R2: Mode code 0 (increment-after) issues addresses base, base+4, ..., base+4N-4. The writeback value is base+4N.
- R3: Mode code 1 (increment-before) issues addresses base+4 through base+4N. The writeback value is base+4N.
- R4: Mode code 2 (decrement-after) issues addresses base-4N+4 through base. The writeback value is base-4N.
- R5: Mode code 3 (decrement-before) issues addresses base-4N through base-4. The writeback value is base-4N.
- R6: In every mode, registers are issued in ascending index order. Each address is 4 above the previous one, so the lowest set bit gets the lowest address.
- R7: An operation is illegal when writeback is requested and the mask bit selected by `base_idx_i` is set. In that case the cycle after start shows `done_o` and `err_o` high, no item is issued and `wb_en_o` stays low. The same mask without writeback is legal.
- R8: With an all-zero mask, `done_o` rises the cycle after start and no item is issued. `wb_en_o` follows the writeback request, and `wb_val_o` equals the base.
- R9: `done_o` is high for exactly one cycle, the cycle right after the edge that consumed the last item. `wb_en_o` is high together with `done_o` exactly when writeback was requested and the operation was legal.
- R10: A start strobe that arrives while `busy_o` is high has no effect. No extra item is issued, and the running sequence finishes unchanged.
- R11: `ovf_o` rises together with `done_o` only for a store (`is_load_i`=0) with writeback whose writeback value is unsigned-below `limit_i`.
- R12: After reset, `xfer_valid_o`, `busy_o`, `done_o`, `err_o`, `wb_en_o` and `ovf_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken when not busy |
| is_load_i | input | 1 | 1 = load from memory, 0 = store |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register selection mask |
| mode_i | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wb_req_i | input | 1 | Request base writeback |
| base_idx_i | input | 4 | Index of the base register |
| limit_i | input | 32 | Stack limit for overflow check |
| xfer_ready_i | input | 1 | Consumer accepts the offered item |
| xfer_valid_o | output | 1 | An item is offered |
| xfer_idx_o | output | 4 | Register index of the item |
| xfer_addr_o | output | 32 | Word address of the item |
| xfer_load_o | output | 1 | Direction of the running sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal request, with done |
| wb_en_o | output | 1 | Write the new base, with done |
| wb_val_o | output | 32 | New base value |
| ovf_o | output | 1 | Stack-limit overflow, with done |

## Verification
The properties assume that the base address does not wrap past zero or the top of the address space within a sequence, so that each address is exactly 4 above the previous one. The bench keeps bases well clear of both ends. The properties also assume that ready is a free input that the block never waits on combinationally. The bench drives ready from a pseudo-random shift register after each clock edge. A start issued during busy is expected to be ignored. The bench issues such a start deliberately, with different fields, and relies on the scoreboard to catch any stray item.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } addr_mode_e;
endpackage

// File: rtl/blk_xfer_plan.sv
// Computes the first (lowest) address and the writeback value from the set-bit count.
module blk_xfer_plan
  import blk_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int NREG = 16,
  parameter int WBYTES = 4
) (
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [1:0]      mode_i,
  output logic [AW-1:0]   first_addr_o,
  output logic [AW-1:0]   wb_addr_o
);
  localparam int CW = $clog2(NREG + 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] span;
  addr_mode_e    mode;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(mask_i[i]);
  end

  assign span = AW'(cnt) * AW'(WBYTES);
  assign mode = addr_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      AM_INC_AFTER: begin
        first_addr_o = base_i;
        wb_addr_o    = base_i + span;
      end
      AM_INC_BEFORE: begin
        first_addr_o = base_i + AW'(WBYTES);
        wb_addr_o    = base_i + span;
      end
      AM_DEC_AFTER: begin
        first_addr_o = base_i - span + AW'(WBYTES);
        wb_addr_o    = base_i - span;
      end
      default: begin
        first_addr_o = base_i - span;
        wb_addr_o    = base_i - span;
      end
    endcase
  end
endmodule

// File: rtl/blk_xfer_lowpick.sv
// Index of the lowest set bit; zero when the mask is empty.
module blk_xfer_lowpick #(
  parameter int NREG = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (mask_i[i]) idx_o = IDXW'(i);
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW = 32,
  parameter int NREG = 16,
  parameter int WBYTES = 4,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            is_load_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [1:0]      mode_i,
  input  logic            wb_req_i,
  input  logic [IDXW-1:0] base_idx_i,
  input  logic [AW-1:0]   limit_i,
  input  logic            xfer_ready_i,
  output logic            xfer_valid_o,
  output logic [IDXW-1:0] xfer_idx_o,
  output logic [AW-1:0]   xfer_addr_o,
  output logic            xfer_load_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            wb_en_o,
  output logic [AW-1:0]   wb_val_o,
  output logic            ovf_o
);
  logic [AW-1:0]   first_addr, wb_addr;
  logic [NREG-1:0] rem_q, rem_next;
  logic [AW-1:0]   addr_q, wb_val_q;
  logic            busy_q, done_q, err_q, wb_en_q, ovf_q;
  logic            load_q, wbreq_q, ovf_pend_q;
  logic            accept, illegal, beat, ovf_now;

  blk_xfer_plan #(.AW(AW), .NREG(NREG), .WBYTES(WBYTES)) u_plan (
    .base_i(base_i), .mask_i(mask_i), .mode_i(mode_i),
    .first_addr_o(first_addr), .wb_addr_o(wb_addr)
  );

  blk_xfer_lowpick #(.NREG(NREG), .IDXW(IDXW)) u_pick (
    .mask_i(rem_q), .idx_o(xfer_idx_o)
  );

  assign accept   = start_i && !busy_q;
  assign illegal  = wb_req_i && mask_i[base_idx_i];
  assign beat     = busy_q && xfer_ready_i;
  assign rem_next = rem_q & (rem_q - NREG'(1));
  assign ovf_now  = !is_load_i && wb_req_i && (wb_addr < limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      addr_q     <= '0;
      wb_val_q   <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      wb_en_q    <= 1'b0;
      ovf_q      <= 1'b0;
      load_q     <= 1'b0;
      wbreq_q    <= 1'b0;
      ovf_pend_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      wb_en_q <= 1'b0;
      ovf_q   <= 1'b0;
      if (accept) begin
        load_q <= is_load_i;
        if (illegal) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else if (mask_i == '0) begin
          done_q   <= 1'b1;
          wb_en_q  <= wb_req_i;
          wb_val_q <= base_i;
          ovf_q    <= !is_load_i && wb_req_i && (base_i < limit_i);
        end else begin
          busy_q     <= 1'b1;
          rem_q      <= mask_i;
          addr_q     <= first_addr;
          wb_val_q   <= wb_addr;
          wbreq_q    <= wb_req_i;
          ovf_pend_q <= ovf_now;
        end
      end else if (beat) begin
        rem_q  <= rem_next;
        addr_q <= addr_q + AW'(WBYTES);
        if (rem_next == '0) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          wb_en_q <= wbreq_q;
          ovf_q   <= ovf_pend_q;
        end
      end
    end
  end

  assign xfer_valid_o = busy_q;
  assign xfer_addr_o  = addr_q;
  assign xfer_load_o  = load_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign wb_en_o      = wb_en_q;
  assign wb_val_o     = wb_val_q;
  assign ovf_o        = ovf_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int AW = 32,
  parameter int NREG = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xfer_ready_i,
  input logic            xfer_valid_o,
  input logic [IDXW-1:0] xfer_idx_o,
  input logic [AW-1:0]   xfer_addr_o,
  input logic            done_o,
  input logic            err_o,
  input logic            wb_en_o,
  input logic            ovf_o
);
  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_idx_o)));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || xfer_addr_o == $past(xfer_addr_o) + AW'(4)));

  a_r6_idx_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || xfer_idx_o > $past(xfer_idx_o)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !xfer_valid_o);

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && !wb_en_o));

  a_r11_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (done_o && !err_o));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk u_chk (.*);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, is_load_i = 1'b0, wb_req_i = 1'b0;
  logic [31:0] base_i = '0, limit_i = '0;
  logic [15:0] mask_i = '0;
  logic [1:0]  mode_i = '0;
  logic [3:0]  base_idx_i = '0;
  logic        xfer_ready_i = 1'b1;
  logic        xfer_valid_o, xfer_load_o, busy_o, done_o, err_o, wb_en_o, ovf_o;
  logic [3:0]  xfer_idx_o;
  logic [31:0] xfer_addr_o, wb_val_o;

  int total = 0, bad = 0, cyc = 0, last_hs = -1;
  logic bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [35:0] exp_q[$];
  string cur_tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    xfer_ready_i <= bp_en ? lfsr[0] : 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected items on each handshake
  always @(negedge clk) begin
    if (rst_n && xfer_valid_o && xfer_ready_i) begin
      last_hs = cyc;
      if (exp_q.size() == 0) check({cur_tag, " R10 stray item"}, {28'd0, xfer_idx_o}, 32'hFFFF);
      else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        check({cur_tag, " R6 idx"}, {28'd0, xfer_idx_o}, {28'd0, e[35:32]});
        check({cur_tag, " addr"}, xfer_addr_o, e[31:0]);
      end
    end
  end

  task automatic run_op(input string tag, input logic ld, input logic [31:0] base,
                        input logic [15:0] mask, input logic [1:0] mode, input logic wb,
                        input logic [3:0] bidx, input logic [31:0] lim, input logic inject);
    int n;
    logic [31:0] a, wbv;
    logic ill, eovf;
    int st, wait_c;
    bit seen;
    n = $countones(mask);
    ill = wb && mask[bidx];
    case (mode)
      2'd0: begin a = base;                    wbv = base + 32'(4*n); end
      2'd1: begin a = base + 4;                wbv = base + 32'(4*n); end
      2'd2: begin a = base - 32'(4*n) + 4;     wbv = base - 32'(4*n); end
      default: begin a = base - 32'(4*n);      wbv = base - 32'(4*n); end
    endcase
    eovf = !ill && !ld && wb && (wbv < lim);
    cur_tag = tag;
    if (!ill)
      for (int i = 0; i < 16; i++)
        if (mask[i]) begin exp_q.push_back({4'(i), a}); a = a + 4; end
    @(negedge clk);
    start_i = 1'b1; is_load_i = ld; base_i = base; mask_i = mask;
    mode_i = mode; wb_req_i = wb; base_idx_i = bidx; limit_i = lim;
    st = cyc;
    @(negedge clk);
    start_i = 1'b0;
    seen = 0; wait_c = 0;
    while (!seen && wait_c < 3000) begin
      if (done_o) seen = 1;
      else begin
        if (inject && wait_c == 2) begin
          start_i = 1'b1; mask_i = 16'h0001; base_i = 32'h4000; mode_i = 2'd0; wb_req_i = 1'b0;
        end else start_i = 1'b0;
        @(negedge clk);
        wait_c++;
      end
    end
    start_i = 1'b0;
    check({tag, " R9 done seen"}, {31'd0, seen}, 32'd1);
    if (n == 0 || ill) check({tag, " R8 done timing"}, 32'(cyc), 32'(st + 1));
    else check({tag, " R9 done after last"}, 32'(cyc), 32'(last_hs + 1));
    check({tag, " R7 err"}, {31'd0, err_o}, {31'd0, ill});
    check({tag, " R9 wb_en"}, {31'd0, wb_en_o}, {31'd0, wb && !ill});
    if (wb && !ill) check({tag, " wb_val"}, wb_val_o, wbv);
    check({tag, " R11 ovf"}, {31'd0, ovf_o}, {31'd0, eovf});
    check({tag, " R1 all items"}, 32'(exp_q.size()), 32'd0);
    @(negedge clk);
    check({tag, " R9 pulse low"}, {31'd0, done_o}, 32'd0);
    repeat (2) begin
      @(negedge clk);
      check({tag, " R10 idle"}, {31'd0, xfer_valid_o}, 32'd0);
    end
    exp_q.delete();
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 valid", {31'd0, xfer_valid_o}, 0);
    check("R12 busy", {31'd0, busy_o}, 0);
    check("R12 done", {31'd0, done_o}, 0);
    check("R12 err/wb/ovf", {29'd0, err_o, wb_en_o, ovf_o}, 0);
    rst_n = 1'b1;
    run_op("R2 inc-after",  1, 32'h0008_0010, 16'h000E, 2'd0, 1, 4'd0, 0, 0);
    run_op("R3 inc-before", 1, 32'h0008_0010, 16'h000E, 2'd1, 1, 4'd0, 0, 0);
    run_op("R4 dec-after",  1, 32'h0000_900C, 16'h000E, 2'd2, 1, 4'd0, 0, 0);
    run_op("R5 dec-before push", 0, 32'h0008_0014, 16'h0012, 2'd3, 1, 4'd13, 0, 0);
    run_op("R11 push overflow", 0, 32'h0008_0014, 16'h0012, 2'd3, 1, 4'd13, 32'h0008_0010, 0);
    run_op("R11 load no ovf", 1, 32'h0008_0014, 16'h0012, 2'd3, 1, 4'd13, 32'hFFFF_0000, 0);
    run_op("R7 illegal", 1, 32'h0001_0000, 16'h0413, 2'd0, 1, 4'd10, 0, 0);
    run_op("R7 legal no wb", 1, 32'h0001_0000, 16'h0413, 2'd0, 0, 4'd10, 0, 0);
    run_op("R8 empty", 0, 32'h0002_0000, 16'h0000, 2'd3, 1, 4'd2, 0, 0);
    run_op("R6 sparse dec-after", 0, 32'h0003_0000, 16'h8101, 2'd2, 0, 4'd0, 0, 0);
    run_op("R10 start while busy", 1, 32'h0005_0000, 16'h00FF, 2'd1, 1, 4'd12, 0, 1);
    bp_en = 1'b1;
    run_op("R1 full mask stalls", 1, 32'h0006_0000, 16'hFFFF, 2'd0, 0, 4'd0, 0, 0);
    run_op("R1 R5 stalls dec-before", 0, 32'h0007_0000, 16'h5A5A, 2'd3, 1, 4'd0, 32'h0006_FFF0, 0);
    bp_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule